// File: doc/BRIEF.md
# Edge-Detect Interrupt Controller

This block watches a bank of 24 digital input lines that are already synchronised to its clock. Each clock it compares every line with the value the line had on the previous clock. A low-to-high change counts as a rising edge and a high-to-low change counts as a falling edge. An edge counts only when the line's own direction mask bit is set and the matching global direction enable is on. A counted edge latches an edge flag. A further counted edge that arrives while the edge flag is still set latches an overflow flag.

The two flags, each qualified by its own reporting enable, form an interrupt-pending bit. That bit, gated by an interrupt enable, drives a level-sensitive interrupt line. The line stays asserted until software clears the flags or turns reporting off.

Software reaches the block through a byte-wide register port. A write takes effect on the clock edge where the write strobe is high. A read returns, combinationally, the register selected by the address. The port holds the per-line rising and falling masks, one byte lane per eight lines, a control byte, a status byte, and a write-one-to-clear byte.

Top module: `edge_irq_ctrl`

## Requirements
- R1: After reset, every mask lane, the control register and the status register read 0, and the interrupt output is low.
- R2: Rising masks are at addresses 0, 1 and 2 and falling masks at 4, 5 and 6. Lane k covers lines 8k to 8k+7, with bit j of the lane covering line 8k+j. A write to one lane leaves the other lanes unchanged, and every lane reads back exactly what was last written to it.
- R3: The control register is at address 8. Its bits are: bit 0 edge reporting enable, bit 1 overflow reporting enable, bit 2 interrupt enable, bit 3 global rising enable, bit 4 global falling enable. Bits 7 to 5 read 0.
- R4: A 0-to-1 change on a line whose rising mask bit is set, with control bit 3 set, sets the edge flag on that clock edge.
- R5: A 1-to-0 change on a line whose falling mask bit is set, with control bit 4 set, sets the edge flag on that clock edge.
- R6: A change on a line whose mask bit for that direction is clear, or whose global direction enable is off, changes no flag.
- R7: The status register is at address 9. Bit 0 is the edge flag and bit 1 is the overflow flag. Bit 2 is the pending bit, equal to (edge flag AND control bit 0) OR (overflow flag AND control bit 1). Bits 7 to 3 read 0.
- R8: The interrupt output equals the pending bit AND control bit 2, and holds its level until a flag is cleared or the control register changes.
- R9: A counted edge that arrives while the edge flag is already set sets the overflow flag.
- R10: A write to address 10 clears the edge flag when bit 3 is 1 and the overflow flag when bit 2 is 1. Both may be cleared in one write, and the other bits have no effect. Address 10 and the unmapped addresses read 0.
- R11: When a counted edge and a clear of the edge flag happen on the same clock, the edge flag stays set.
- R12: Writing 0 to the control register brings the interrupt output low and stops further edges from being counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Asynchronous active-low reset |
| lineIn | input | 24 | Synchronised input lines |
| regAddr | input | 4 | Register address |
| regWr | input | 1 | Write strobe for the addressed register |
| regWrData | input | 8 | Write data byte |
| regRdData | output | 8 | Read data of the addressed register |
| irqOut | output | 1 | Level-sensitive interrupt request |

## Verification
The assertions check on every cycle the flag rules that hold whatever the traffic. A qualified rising or falling edge always sets the edge flag. The edge flag never rises without a counted edge. A second edge while the flag is set always sets overflow. A clear without a new edge drops the flag, and a clear that races an edge loses. A mask lane moves only on its own write strobe. The interrupt output holds steady while nothing clears or reconfigures. The bench scenarios cover what a single-cycle property cannot state as one rule. These are the exact byte values read back from the lanes and the control register, the status byte under each combination of reporting enables, the clear byte's ignored bits, and a long pseudo-random run of line activity. In that run a behavioural model tracks every line and flag.

// File: rtl/edge_pkg.sv
`timescale 1ns/1ps
package edge_pkg;
  localparam int LINE_COUNT = 24;
  localparam int LANE_W     = 8;
  localparam int LANE_CNT   = LINE_COUNT / LANE_W;
  localparam int LANE_IDX_W = (LANE_CNT > 1) ? $clog2(LANE_CNT) : 1;
  localparam int ADDR_W     = 4;
  localparam int CTRL_W     = 5;
  localparam int STAT_W     = 3;

  localparam int RISE_BASE  = 0;
  localparam int FALL_BASE  = 4;
  localparam int CTRL_ADDR  = 8;
  localparam int STAT_ADDR  = 9;
  localparam int CLR_ADDR   = 10;

  // control bit positions
  localparam int CB_EDGE = 0;
  localparam int CB_OVF  = 1;
  localparam int CB_IRQ  = 2;
  localparam int CB_RISE = 3;
  localparam int CB_FALL = 4;

  // clear byte bit positions
  localparam int CLR_OVF_BIT  = 2;
  localparam int CLR_EDGE_BIT = 3;

  typedef enum logic [2:0] {
    RD_NONE,
    RD_RISE,
    RD_FALL,
    RD_CTRL,
    RD_STAT
  } rdsel_e;

  typedef struct packed {
    logic [LANE_CNT-1:0] riseWr;
    logic [LANE_CNT-1:0] fallWr;
    logic                ctrlWr;
    logic                clrEdge;
    logic                clrOvf;
    logic [LANE_W-1:0]   wrByte;
  } strobe_t;
endpackage

// File: rtl/edge_regctl.sv
`timescale 1ns/1ps
module edge_regctl
  import edge_pkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [ADDR_W-1:0]     regAddr,
  input  logic                  regWr,
  input  logic [LANE_W-1:0]     regWrData,
  output strobe_t               stb,
  output rdsel_e                rdSel,
  output logic [LANE_IDX_W-1:0] rdLane
);

  // Address decode: one strobe per written location, one read select.
  always_comb begin
    stb    = '0;
    rdSel  = RD_NONE;
    rdLane = '0;
    for (int k = 0; k < LANE_CNT; k++) begin
      if (regAddr == ADDR_W'(RISE_BASE + k)) begin
        rdSel         = RD_RISE;
        rdLane        = LANE_IDX_W'(k);
        stb.riseWr[k] = regWr;
      end
      if (regAddr == ADDR_W'(FALL_BASE + k)) begin
        rdSel         = RD_FALL;
        rdLane        = LANE_IDX_W'(k);
        stb.fallWr[k] = regWr;
      end
    end
    if (regAddr == ADDR_W'(CTRL_ADDR)) begin
      rdSel      = RD_CTRL;
      stb.ctrlWr = regWr;
    end
    if (regAddr == ADDR_W'(STAT_ADDR)) begin
      rdSel = RD_STAT;
    end
    if (regAddr == ADDR_W'(CLR_ADDR)) begin
      stb.clrEdge = regWr && regWrData[CLR_EDGE_BIT];
      stb.clrOvf  = regWr && regWrData[CLR_OVF_BIT];
    end
    stb.wrByte = regWrData;
  end

  AST_ONE_TARGET: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({stb.riseWr, stb.fallWr, stb.ctrlWr})); // R2

  AST_CLR_NEEDS_WR: assert property (@(posedge clk) disable iff (!rstN)
    (stb.clrEdge || stb.clrOvf) |-> (regWr && regAddr == ADDR_W'(CLR_ADDR))); // R10

endmodule

// File: rtl/edge_datapath.sv
`timescale 1ns/1ps
module edge_datapath
  import edge_pkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [LINE_COUNT-1:0] lineIn,
  input  strobe_t               stb,
  input  rdsel_e                rdSel,
  input  logic [LANE_IDX_W-1:0] rdLane,
  output logic [LANE_W-1:0]     rdData,
  output logic                  irqOut
);

  logic [LANE_W-1:0]     riseLane [LANE_CNT];
  logic [LANE_W-1:0]     fallLane [LANE_CNT];
  logic [LINE_COUNT-1:0] riseMask;
  logic [LINE_COUNT-1:0] fallMask;
  logic [LINE_COUNT-1:0] prevIn;
  logic [LINE_COUNT-1:0] riseHit;
  logic [LINE_COUNT-1:0] fallHit;
  logic [CTRL_W-1:0]     ctrlReg;
  logic                  edgeFlag;
  logic                  ovfFlag;
  logic                  anyHit;
  logic                  pending;

  // Per-lane mask storage
  for (genvar g = 0; g < LANE_CNT; g++) begin : gLane
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        riseLane[g] <= '0;
      end else if (stb.riseWr[g]) begin
        riseLane[g] <= stb.wrByte;
      end
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        fallLane[g] <= '0;
      end else if (stb.fallWr[g]) begin
        fallLane[g] <= stb.wrByte;
      end
    end

    assign riseMask[g*LANE_W +: LANE_W] = riseLane[g];
    assign fallMask[g*LANE_W +: LANE_W] = fallLane[g];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlReg <= '0;
    end else if (stb.ctrlWr) begin
      ctrlReg <= stb.wrByte[CTRL_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevIn <= '0;
    end else begin
      prevIn <= lineIn;
    end
  end

  // Edge qualification
  always_comb begin
    riseHit = lineIn & ~prevIn & riseMask & {LINE_COUNT{ctrlReg[CB_RISE]}};
    fallHit = ~lineIn & prevIn & fallMask & {LINE_COUNT{ctrlReg[CB_FALL]}};
    anyHit  = |(riseHit | fallHit);
  end

  // Flags: a new edge wins over a clear in the same cycle
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      edgeFlag <= 1'b0;
      ovfFlag  <= 1'b0;
    end else begin
      edgeFlag <= anyHit | (edgeFlag & ~stb.clrEdge);
      ovfFlag  <= (anyHit & edgeFlag) | (ovfFlag & ~stb.clrOvf);
    end
  end

  assign pending = (edgeFlag & ctrlReg[CB_EDGE]) | (ovfFlag & ctrlReg[CB_OVF]);
  assign irqOut  = pending & ctrlReg[CB_IRQ];

  // Read mux
  always_comb begin
    unique case (rdSel)
      RD_RISE: rdData = riseLane[rdLane];
      RD_FALL: rdData = fallLane[rdLane];
      RD_CTRL: rdData = LANE_W'(ctrlReg);
      RD_STAT: rdData = LANE_W'({pending, ovfFlag, edgeFlag});
      default: rdData = '0;
    endcase
  end

  AST_RISE_SETS: assert property (@(posedge clk) disable iff (!rstN)
    (|riseHit) |=> edgeFlag); // R4

  AST_FALL_SETS: assert property (@(posedge clk) disable iff (!rstN)
    (|fallHit) |=> edgeFlag); // R5

  AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rstN)
    $rose(edgeFlag) |-> $past(anyHit)); // R6

  AST_OVF_SETS: assert property (@(posedge clk) disable iff (!rstN)
    (anyHit && edgeFlag) |=> ovfFlag); // R9

  AST_CLEAR_EDGE: assert property (@(posedge clk) disable iff (!rstN)
    (stb.clrEdge && !anyHit) |=> !edgeFlag); // R10

  AST_CLEAR_RACE: assert property (@(posedge clk) disable iff (!rstN)
    (stb.clrEdge && anyHit) |=> edgeFlag); // R11

  AST_IRQ_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (irqOut && !stb.clrEdge && !stb.clrOvf && !stb.ctrlWr) |=> irqOut); // R8

  AST_CTRL_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (stb.ctrlWr && stb.wrByte == '0) |=> !irqOut); // R12

  AST_MASK_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !(|stb.riseWr) |=> $stable(riseMask)); // R2

endmodule

// File: rtl/edge_irq_ctrl.sv
`timescale 1ns/1ps
module edge_irq_ctrl
  import edge_pkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [LINE_COUNT-1:0] lineIn,
  input  logic [ADDR_W-1:0]     regAddr,
  input  logic                  regWr,
  input  logic [LANE_W-1:0]     regWrData,
  output logic [LANE_W-1:0]     regRdData,
  output logic                  irqOut
);

  strobe_t               stb;
  rdsel_e                rdSel;
  logic [LANE_IDX_W-1:0] rdLane;

  edge_regctl u_ctl (
    .clk       (clk),
    .rstN      (rstN),
    .regAddr   (regAddr),
    .regWr     (regWr),
    .regWrData (regWrData),
    .stb       (stb),
    .rdSel     (rdSel),
    .rdLane    (rdLane)
  );

  edge_datapath u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .lineIn (lineIn),
    .stb    (stb),
    .rdSel  (rdSel),
    .rdLane (rdLane),
    .rdData (regRdData),
    .irqOut (irqOut)
  );

endmodule

// File: tb/sim_edge_irq_ctrl.sv
`timescale 1ns/1ps
module sim_edge_irq_ctrl;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [23:0] lineIn = '0;
  logic [3:0]  regAddr = 4'd9;
  logic        regWr = 1'b0;
  logic [7:0]  regWrData = '0;
  logic [7:0]  regRdData;
  logic        irqOut;

  int nChecks = 0;
  int nFail = 0;

  always #2.5 clk = ~clk;

  edge_irq_ctrl u0 (
    .clk       (clk),
    .rstN      (rstN),
    .lineIn    (lineIn),
    .regAddr   (regAddr),
    .regWr     (regWr),
    .regWrData (regWrData),
    .regRdData (regRdData),
    .irqOut    (irqOut)
  );

  // Behavioural reference model
  logic [23:0] mRise, mFall, mPrev;
  logic [7:0]  mCtrl;
  logic        mEdge, mOvf;

  always @(posedge clk) begin
    logic hit;
    if (!rstN) begin
      mRise = '0; mFall = '0; mPrev = '0; mCtrl = '0; mEdge = 0; mOvf = 0;
    end else begin
      hit = 0;
      for (int i = 0; i < 24; i++) begin
        if (!mPrev[i] && lineIn[i] && mRise[i] && mCtrl[3]) hit = 1;
        if (mPrev[i] && !lineIn[i] && mFall[i] && mCtrl[4]) hit = 1;
      end
      if (hit && mEdge) mOvf = 1;
      else if (regWr && regAddr == 10 && regWrData[2]) mOvf = 0;
      if (hit) mEdge = 1;
      else if (regWr && regAddr == 10 && regWrData[3]) mEdge = 0;
      if (regWr) begin
        if (regAddr < 3) mRise[regAddr*8 +: 8] = regWrData;
        if (regAddr >= 4 && regAddr < 7) mFall[(regAddr-4)*8 +: 8] = regWrData;
        if (regAddr == 8) mCtrl = {3'b000, regWrData[4:0]};
      end
      mPrev = lineIn;
    end
  end

  function automatic logic mPend();
    return (mEdge && mCtrl[0]) || (mOvf && mCtrl[1]);
  endfunction

  function automatic logic [7:0] mRead(input logic [3:0] a);
    if (a < 3) return mRise[a*8 +: 8];
    if (a >= 4 && a < 7) return mFall[(a-4)*8 +: 8];
    if (a == 8) return mCtrl;
    if (a == 9) return {5'b0, mPend(), mOvf, mEdge};
    return 8'h00;
  endfunction

  function automatic string tagFor(input logic [3:0] a);
    if (a == 8) return "R3";
    if (a == 9) return "R7";
    if (a < 7) return "R2";
    return "R10";
  endfunction

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic compareNow();
    check(32'(irqOut), 32'(mPend() && mCtrl[2]), "R8 model irq");
    check(32'(regRdData), 32'(mRead(regAddr)), tagFor(regAddr));
  endtask

  task automatic cycle();
    @(posedge clk);
    #1;
    compareNow();
  endtask

  task automatic doWrite(input logic [3:0] a, input logic [7:0] d);
    regAddr = a; regWrData = d; regWr = 1'b1;
    cycle();
    regWr = 1'b0; regAddr = 4'd9;
  endtask

  task automatic expectRead(input logic [3:0] a, input logic [7:0] exp, input string tag);
    regAddr = a;
    #0.5;
    check(32'(regRdData), 32'(exp), tag);
    regAddr = 4'd9;
    #0.1;
  endtask

  task automatic setLines(input logic [23:0] v);
    lineIn = v;
    cycle();
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", nChecks, nFail);
    $finish;
  end

  initial begin : main
    logic [23:0] lfsr;
    repeat (3) @(posedge clk);
    #1;
    rstN = 1'b1;
    cycle();

    // R1 reset state
    for (int a = 0; a < 11; a++) expectRead(4'(a), 8'h00, "R1 reset read");
    check(32'(irqOut), 0, "R1 irq after reset");

    // R2 mask lanes
    doWrite(0, 8'hA5); doWrite(1, 8'h3C); doWrite(2, 8'h81);
    doWrite(4, 8'h5A); doWrite(5, 8'hC3); doWrite(6, 8'h18);
    expectRead(0, 8'hA5, "R2 rise lane0"); expectRead(1, 8'h3C, "R2 rise lane1");
    expectRead(2, 8'h81, "R2 rise lane2"); expectRead(4, 8'h5A, "R2 fall lane0");
    expectRead(5, 8'hC3, "R2 fall lane1"); expectRead(6, 8'h18, "R2 fall lane2");
    doWrite(1, 8'hFF);
    expectRead(0, 8'hA5, "R2 lane0 kept"); expectRead(1, 8'hFF, "R2 lane1 new");
    expectRead(2, 8'h81, "R2 lane2 kept"); expectRead(5, 8'hC3, "R2 fall untouched");

    // R3 control readback
    doWrite(8, 8'hFF);
    expectRead(8, 8'h1F, "R3 ctrl upper bits zero");
    expectRead(3, 8'h00, "R10 unmapped reads zero");

    // R4 rising edge on line0 (rise lane0 bit0 set)
    setLines(24'h000001);
    expectRead(9, 8'h05, "R4 rise sets edge");
    check(32'(irqOut), 1, "R8 irq asserted");
    cycle();
    check(32'(irqOut), 1, "R8 irq level held");
    doWrite(10, 8'h08);
    expectRead(9, 8'h00, "R10 edge cleared");

    // R6 unmasked directions
    setLines(24'h000000);           // line0 falls, fall lane0 bit0 clear
    expectRead(9, 8'h00, "R6 unmasked fall");
    setLines(24'h000040);           // line6 rises, rise lane0 bit6 clear
    expectRead(9, 8'h00, "R6 unmasked rise");
    setLines(24'h000042);           // line1 rises, rise bit1 clear
    expectRead(9, 8'h00, "R6 unmasked rise line1");

    // R5 falling edge on line1 (fall lane0 bit1 set)
    setLines(24'h000040);
    expectRead(9, 8'h05, "R5 fall sets edge");
    doWrite(10, 8'h0C);

    // R6 global rising enable off
    doWrite(8, 8'h17);
    setLines(24'h000041);
    expectRead(9, 8'h00, "R6 global rise off");
    doWrite(8, 8'h1F);
    setLines(24'h000040);
    expectRead(9, 8'h00, "R6 no edge on unmasked fall");

    // R9 overflow
    setLines(24'h000041);
    setLines(24'h000040);
    setLines(24'h000041);
    expectRead(9, 8'h07, "R9 overflow set");

    // R7 pending under reporting enables
    doWrite(8, 8'h1E);
    expectRead(9, 8'h07, "R7 overflow alone pends");
    doWrite(8, 8'h1C);
    expectRead(9, 8'h03, "R7 no reporting");
    check(32'(irqOut), 0, "R8 irq low without pending");
    doWrite(8, 8'h1B);
    expectRead(9, 8'h07, "R7 pending with irq off");
    check(32'(irqOut), 0, "R8 irq gated");
    doWrite(8, 8'h1F);

    // R10 clear bits
    doWrite(10, 8'h04);
    expectRead(9, 8'h05, "R10 clear overflow only");
    doWrite(10, 8'hF3);
    expectRead(9, 8'h05, "R10 other bits ignored");
    expectRead(10, 8'h00, "R10 clear reads zero");
    doWrite(10, 8'h0C);
    expectRead(9, 8'h00, "R10 clear both");

    // R11 clear racing an edge
    setLines(24'h000040);
    setLines(24'h000041);
    setLines(24'h000040);
    lineIn = 24'h000041;
    doWrite(10, 8'h08);
    expectRead(9, 8'h07, "R11 edge wins over clear");
    doWrite(10, 8'h0C);

    // R12 control zero
    setLines(24'h000040);
    setLines(24'h000041);
    check(32'(irqOut), 1, "R12 irq before disable");
    doWrite(8, 8'h00);
    check(32'(irqOut), 0, "R12 irq after ctrl zero");
    expectRead(9, 8'h01, "R12 flags kept, no pending");
    setLines(24'h000040);
    setLines(24'h000041);
    expectRead(9, 8'h01, "R12 no new edges counted");

    // Pseudo-random sweep against the model
    doWrite(10, 8'h0C);
    doWrite(8, 8'h1F);
    doWrite(4, 8'hF0); doWrite(6, 8'h0F); doWrite(2, 8'h3C);
    lfsr = 24'hACE1B5;
    for (int n = 0; n < 600; n++) begin
      lfsr = {lfsr[22:0], lfsr[23] ^ lfsr[22] ^ lfsr[21] ^ lfsr[16]};
      lineIn = lfsr;
      if (n % 7 == 3) doWrite(10, {4'b0, lfsr[3:2], 2'b0});
      else if (n % 41 == 5) doWrite(8, {3'b0, lfsr[8:4]});
      else if (n % 53 == 9) doWrite(4'(lfsr[1:0]), lfsr[15:8]);
      else cycle();
    end

    $display("TB_RESULT checks=%0d failures=%0d", nChecks, nFail);
    $finish;
  end

endmodule